// File: doc/BRIEF.md
# SPI Master Bit-Clock Divider

This block derives the serial clock timing of an SPI master from the bus clock. A single 8-bit configuration byte holds two 3-bit fields. One is a linear prescale `P` and the other a power-of-two exponent `S`. Together they divide the bus clock by `(P+1)·2^(S+1)`, so the divisor runs from 2 up to 2048.

While the transfer engine signals that it is busy, the block emits a one-cycle strobe at every serial-clock half period. It also produces a matching serial clock level that starts low and toggles on each strobe. The transfer engine shifts and samples on these strobes.

If the divisor fields are changed while a transfer is running, the block raises a one-cycle abort pulse so that the shift logic returns to idle. The half-period counter restarts at the same moment. Rewriting the current value, or changing the value while idle, aborts nothing. The configuration byte can be written and read back at any time, and the unused bits always read as zero.

Top module: `spi_brg_top`

## Requirements
- R1: While reset is applied, and after it is released, `rd_data`, `half_tick`, `sck` and `abort` are all 0. The configuration fields reset to P=0, S=0.
- R2: A write stores P from `wr_data[6:4]` and S from `wr_data[2:0]`. From the first sample after the write edge, `rd_data` shows P in bits 6:4, S in bits 2:0 and zeros elsewhere, and it holds while no write occurs.
- R3: Bits 7 and 3 of a write are ignored. They read back as 0 and do not alter the divisor.
- R4: While `busy` stays high, `half_tick` pulses for one bus cycle every `(P+1)·2^S` bus cycles. The `sck` period is therefore `(P+1)·2^(S+1)` bus cycles.
- R5: The counter is held cleared while `busy` is low, and no `half_tick` occurs then. The first `half_tick` of a transfer follows the `(P+1)·2^S`-th rising edge at which `busy` is sampled high.
- R6: `sck` is low while idle, rises on the first `half_tick` of a transfer and inverts on every later `half_tick`.
- R7: A write that changes P or S while `busy` is high makes `abort` high for exactly the one cycle after the write edge. The same edge forces `sck` low and restarts the count, so the next `half_tick` arrives a full new half period after the write.
- R8: A write of the value already held, while `busy` is high, gives no `abort` and does not disturb the `half_tick` timing.
- R9: A field change while `busy` is low gives no `abort`.
- R10: The largest setting (P=7, S=7) gives a half period of 1024 bus cycles, and the smallest (P=0, S=0) gives a `half_tick` on every bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration write byte |
| busy | input | 1 | Transfer engine has a transfer in progress |
| rd_data | output | 8 | Registered configuration read-back |
| half_tick | output | 1 | One-cycle strobe at each serial-clock half period |
| sck | output | 1 | Serial clock level derived from the strobes |
| abort | output | 1 | One-cycle pulse: divisor changed during a transfer |

## Verification
The bench measures the interval from the start of `busy` to the first strobe, and then from strobe to strobe. It does this for several settings whose half periods are 1, 24, 128 and 1024 cycles. Mixed settings such as P=3, S=5 and P=5, S=2 can only pass if the prescale and the exponent are applied independently and to the correct field. The 1 and 1024 settings test both ends of the counter width. Further patterns cover a write to all ones and a write to the reserved bits alone, which separates reserved-bit masking from field decoding. They also cover a changing write during a transfer and an identical rewrite during a transfer, which separates genuine changes from mere write activity. A changing write while idle shows that the abort depends on `busy`.

// File: rtl/spi_brg_pkg.sv
package spi_brg_pkg;
  localparam int PRE_W   = 3;
  localparam int SEL_W   = 3;
  localparam int REG_W   = 8;
  localparam int PRE_LSB = 4;
  localparam int SEL_LSB = 0;
  // (P+1) needs PRE_W+1 bits, shifted by up to 2^SEL_W-1 places
  localparam int HALF_W  = PRE_W + (1 << SEL_W);

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SEL_W-1:0] sel;
  } brg_cfg_t;
endpackage

// File: rtl/brg_rst_sync.sv
module brg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/brg_cfg_reg.sv
module brg_cfg_reg
  import spi_brg_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output brg_cfg_t          cfg,
  output logic              cfg_change,
  output logic [DATA_W-1:0] rd_data,
  output logic              abort
);
  brg_cfg_t          cfg_q, cfg_nxt, wr_cfg;
  logic [DATA_W-1:0] rd_q, rd_nxt;
  logic              abort_q, abort_nxt;

  // Field extraction; reserved positions are simply never looked at
  always_comb begin
    wr_cfg.pre = wr_data[PRE_LSB +: PRE_W];
    wr_cfg.sel = wr_data[SEL_LSB +: SEL_W];
  end

  assign cfg_change = wr_en && (wr_cfg != cfg_q);

  always_comb begin
    cfg_nxt   = wr_en ? wr_cfg : cfg_q;
    abort_nxt = cfg_change && busy;
    rd_nxt    = '0;
    rd_nxt[PRE_LSB +: PRE_W] = cfg_nxt.pre;
    rd_nxt[SEL_LSB +: SEL_W] = cfg_nxt.sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rd_q    <= '0;
      abort_q <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= cfg_nxt;
      rd_q    <= rd_nxt;
      abort_q <= abort_nxt;
    end
  end

  assign cfg     = cfg_q;
  assign rd_data = rd_q;
  assign abort   = abort_q;

  assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> ($past(busy) && $past(wr_en)));

  assert_idle_no_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !abort);

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/brg_half_calc.sv
module brg_half_calc
  import spi_brg_pkg::*;
#(
  parameter int CNT_W = HALF_W
) (
  input  brg_cfg_t   cfg,
  output logic [CNT_W-1:0] half
);
  logic [CNT_W-1:0] lin;

  always_comb begin
    lin  = CNT_W'(cfg.pre) + CNT_W'(1);
    half = lin << cfg.sel;
  end
endmodule

// File: rtl/brg_half_counter.sv
module brg_half_counter #(
  parameter int CNT_W = spi_brg_pkg::HALF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             restart,
  input  logic [CNT_W-1:0] half,
  output logic             half_tick,
  output logic             sck
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             tick_q, tick_nxt;
  logic             sck_q, sck_nxt;
  logic             run, last;

  assign run  = busy && !restart;
  assign last = (cnt_q == half - CNT_W'(1));

  always_comb begin
    tick_nxt = run && last;
    if (!run)       cnt_nxt = '0;
    else if (last)  cnt_nxt = '0;
    else            cnt_nxt = cnt_q + CNT_W'(1);
    sck_nxt  = run ? (sck_q ^ tick_nxt) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      tick_q <= tick_nxt;
      sck_q  <= sck_nxt;
    end
  end

  assign half_tick = tick_q;
  assign sck       = sck_q;

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half);

  assert_tick_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> $past(busy));

  assert_sck_rise_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> half_tick);

  assert_sck_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !sck);
endmodule

// File: rtl/spi_brg_top.sv
module spi_brg_top
  import spi_brg_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int CNT_W  = HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              half_tick,
  output logic              sck,
  output logic              abort
);
  logic             rst_n_int;
  brg_cfg_t         cfg;
  logic             cfg_change;
  logic [CNT_W-1:0] half;

  brg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  brg_cfg_reg #(.DATA_W(DATA_W)) i_cfg_reg (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .busy       (busy),
    .cfg        (cfg),
    .cfg_change (cfg_change),
    .rd_data    (rd_data),
    .abort      (abort)
  );

  brg_half_calc #(.CNT_W(CNT_W)) i_half_calc (
    .cfg  (cfg),
    .half (half)
  );

  brg_half_counter #(.CNT_W(CNT_W)) i_half_counter (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .busy      (busy),
    .restart   (cfg_change),
    .half      (half),
    .half_tick (half_tick),
    .sck       (sck)
  );
endmodule

// File: tb/test_spi_brg_top.sv
module test_spi_brg_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       busy;
  logic [7:0] rd_data;
  logic       half_tick, sck, abort;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  spi_brg_top i_spi_brg_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
    .rd_data(rd_data), .half_tick(half_tick), .sck(sck), .abort(abort)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // write one byte while busy stays as it is; sample after the write edge
  task automatic wr(input logic [7:0] d, input logic [7:0] exp_rd, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk(req, rd_data, exp_rd);
  endtask

  // cycles until half_tick is seen, bounded
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!half_tick && n < 3000);
  endtask

  task automatic measure(input int exp_half, input string req);
    int n;
    busy = 1'b0;
    repeat (2) @(negedge clk);
    busy = 1'b1;
    wait_tick(n);
    chk({req, " first half period"}, n, exp_half);
    chk("R6 sck high after first tick", sck, 1);
    wait_tick(n);
    chk({req, " second half period"}, n, exp_half);
    chk("R6 sck low after second tick", sck, 0);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 sck low when idle", sck, 0);
  endtask

  task automatic t_reset();
    chk("R1 rd_data in reset", rd_data, 0);
    chk("R1 outputs in reset", {half_tick, sck, abort}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R1 outputs after reset", {half_tick, sck, abort}, 0);
    measure(1, "R10 default min divisor");
  endtask

  task automatic t_fields();
    wr(8'h35, 8'h35, "R2 readback P3 S5");
    measure(128, "R4 P3 S5");
    wr(8'h52, 8'h52, "R2 readback P5 S2");
    measure(24, "R4 P5 S2");
  endtask

  task automatic t_reserved();
    wr(8'hFF, 8'h77, "R3 all ones masked");
    measure(1024, "R10 max divisor");
    wr(8'h88, 8'h00, "R3 reserved only");
    measure(1, "R3 reserved no divisor effect");
  endtask

  task automatic t_idle();
    int seen = 0;
    busy = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (half_tick || sck) seen++;
    end
    chk("R5 no tick or sck while idle", seen, 0);
  endtask

  task automatic t_abort();
    int n;
    int ab_late;
    busy = 1'b0;
    wr(8'h21, 8'h21, "R9 readback after idle change");
    chk("R9 no abort on idle change", abort, 0);
    busy = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 no tick yet", half_tick, 0);
    wr_en = 1'b1; wr_data = 8'h10;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R7 abort after change", abort, 1);
    chk("R7 readback new value", rd_data, 8'h10);
    chk("R7 sck forced low", sck, 0);
    n = 0; ab_late = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) ab_late = abort;
    end while (!half_tick && n < 3000);
    chk("R7 abort lasts one cycle", ab_late, 0);
    chk("R7 restart full new half period", n, 2);
    busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_same();
    int n;
    int ab_seen = 0;
    wr(8'h21, 8'h21, "R8 setup P2 S1");
    repeat (2) @(negedge clk);
    busy = 1'b1;
    wr_en = 1'b1; wr_data = 8'h21;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      wr_en = 1'b0;
      if (abort) ab_seen++;
    end while (!half_tick && n < 3000);
    chk("R8 no abort on same value", ab_seen, 0);
    chk("R8 timing undisturbed", n, 6);
    busy = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; busy = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fields();
    t_reserved();
    t_idle();
    t_abort();
    t_same();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule